// File: doc/BRIEF.md
# TLB Invalidate-Flush Walk Sequencer

This block carries out a flush-style invalidate over a translation buffer. The buffer is built from two parts: a small array of variable-page entries and a larger set-associative array of fixed-page entries. In the combined numbering the variable-page entries come first (entries 0 to V-1) and the fixed-page entries follow. Fixed-page set s covers entries V + s·W through V + s·W + W - 1, where W is the number of ways.

A command arrives with the MMU-type field, the invalidate-support field, the current Index value and the size fields, and the block latches all of them. It first checks whether the command is allowed and raises an exception if it is not. Otherwise it picks one of three ranges: the whole buffer, the variable-page array only, or a single fixed-page set. To find that set it walks forward one set per cycle. It then sets the invalid flag of each entry in the range, one entry per clock, through a write port, and pulses `done` when the walk ends. There is no wired-entry boundary, so the walk always starts at the range's first entry, wired entries included.

The controller has six states: IDLE, DECODE, SEEK, WALK, DONE and FAULT. Its transitions are:
- IDLE→DECODE when a command is accepted.
- DECODE→WALK when the range is already known.
- DECODE→SEEK when one fixed-page set must be located.
- DECODE→FAULT when an exception or error applies.
- SEEK→SEEK while the remaining offset is at least one set wide.
- SEEK→WALK once the set is found.
- WALK→WALK until the last entry is written.
- WALK→DONE after the last entry.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `tlb_flush_walker`

## Requirements
- R1: A command is accepted only when `busy` is low and `cmd_valid` is high. `busy` is high from the next cycle up to and including the `done` cycle. A `cmd_valid` pulse while `busy` is high is ignored: it causes no writes and no second `done`.
- R2: With MMU type 1 (single joint array), entries 0 to V-1 are invalidated, and Index and the fixed-page fields are ignored.
- R3: With MMU type 4 and support field 3 (hardware walk), entries 0 to V+F-1 are invalidated, and Index is ignored.
- R4: With MMU type 4 and support field 2 (software walk), an Index below V invalidates entries 0 to V-1.
- R5: With MMU type 4 and support field 2, an Index with V ≤ Index < V+F invalidates only set s = (Index-V)/W. That set covers entries V+s·W through V+s·W+W-1, where W = ways field + 2.
- R6: With MMU type 4 and support field 2, an Index ≥ V+F writes no entry and raises `err_index_range` together with `done`.
- R7: V = 1 + ((ext << 6) | base field). ext is the variable-page extension field when `rev6_mode` is 1 or the extension-definition field is 3. It is the MMU extension field when the extension-definition field is 1. It is 0 otherwise.
- R8: F = (ways field + 2) · 2^(sets field) when the MMU type is 4, and 0 for any other type.
- R9: A walk writes one entry per cycle at ascending, consecutive addresses, and `inv_we` is high only while `busy` is high.
- R10: `done` is a one-cycle pulse. After a walk it comes in the cycle right after the last write.
- R11: MMU types other than 1 and 4, and type 4 with a support field of 0 or 1, raise `exc_reserved` with `done` and write no entry.
- R12: When `cp0_usable` is 0, `exc_cpu_unusable` is raised with `done` and no entry is written. This takes priority over every other outcome.
- R13: At most one of the three exception or error flags is high in any cycle, and each is high only in a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Flush command request |
| cp0_usable | input | 1 | System-control coprocessor access enabled |
| mmu_type | input | 3 | MMU organisation field (1 joint, 4 split) |
| inv_mode | input | 2 | Invalidate-support field (2 software walk, 3 hardware walk) |
| index_val | input | IDX_W | Current Index register value |
| rev6_mode | input | 1 | Newer architecture revision selects the variable-page extension |
| ext_def | input | 2 | Extension-definition field |
| vtlb_ext | input | VEXT_W | Variable-page size extension field |
| mmu_ext | input | MEXT_W | MMU size extension field |
| base_size | input | 6 | Base size field (entries minus one, low part) |
| ftlb_ways | input | WAYS_W | Fixed-page ways field (ways minus two) |
| ftlb_sets | input | SETS_W | Fixed-page sets field (log2 of set count) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| inv_we | output | 1 | Write strobe: set invalid flag of entry `inv_addr` |
| inv_addr | output | CNT_W | Entry being invalidated |
| exc_cpu_unusable | output | 1 | Coprocessor-unusable exception, with `done` |
| exc_reserved | output | 1 | Reserved-instruction exception, with `done` |
| err_index_range | output | 1 | Software-walk Index beyond all entries, with `done` |

## Verification
The hardest situation to reach is a new command arriving in the middle of a walk. That command must leave no trace, neither in the write sequence nor as an extra `done`. To cover it, the driver raises `cmd_valid` a few cycles into a long walk, with a configuration that would have raised an exception. The scoreboard then flags any write or `done` it did not predict. Set selection is driven at both of its edges: the first fixed-page entry, the last entry, and one past the end. This exercises the repeated-subtraction search on its zero-step, multi-step and final-set paths.

// File: rtl/tlb_flush_pkg.sv
package tlb_flush_pkg;

    // Width of the base size field; the extension sits directly above it.
    localparam int BASE_W = 6;

    localparam logic [2:0] MMU_JOINT   = 3'd1;
    localparam logic [2:0] MMU_SPLIT   = 3'd4;
    localparam logic [1:0] INV_SW_WALK = 2'd2;
    localparam logic [1:0] INV_HW_WALK = 2'd3;
    localparam logic [1:0] EXTDEF_MMU  = 2'd1;
    localparam logic [1:0] EXTDEF_VTLB = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_SEEK,
        ST_WALK,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE,
        FLT_COP_UNUSABLE,
        FLT_RESERVED,
        FLT_RANGE
    } fault_t;

    typedef enum logic [1:0] {
        ACT_WALK,
        ACT_SEEK,
        ACT_FAULT
    } action_t;

endpackage

// File: rtl/tlb_size_calc.sv
module tlb_size_calc
    import tlb_flush_pkg::*;
#(
    parameter int VEXT_W = 4,
    parameter int MEXT_W = 3,
    parameter int WAYS_W = 4,
    parameter int SETS_W = 4,
    parameter int CNT_W  = 21
)(
    input  logic              rev6_mode,
    input  logic [1:0]        ext_def,
    input  logic [VEXT_W-1:0] vtlb_ext,
    input  logic [MEXT_W-1:0] mmu_ext,
    input  logic [BASE_W-1:0] base_size,
    input  logic [WAYS_W-1:0] ftlb_ways,
    input  logic [SETS_W-1:0] ftlb_sets,
    input  logic [2:0]        mmu_type,
    output logic [CNT_W-1:0]  vtlb_size,
    output logic [CNT_W-1:0]  total_size,
    output logic [CNT_W-1:0]  way_count
);

    logic [VEXT_W-1:0] size_ext;
    logic [CNT_W-1:0]  ftlb_size;

    always_comb begin
        if (rev6_mode || ext_def == EXTDEF_VTLB) begin
            size_ext = vtlb_ext;
        end else if (ext_def == EXTDEF_MMU) begin
            size_ext = VEXT_W'(mmu_ext);
        end else begin
            size_ext = '0;
        end
    end

    always_comb begin
        vtlb_size = CNT_W'({size_ext, base_size}) + CNT_W'(1);
        way_count = CNT_W'(ftlb_ways) + CNT_W'(2);
        ftlb_size = (mmu_type == MMU_SPLIT) ? (way_count << ftlb_sets) : '0;
        total_size = vtlb_size + ftlb_size;
    end

endmodule

// File: rtl/tlb_range_sel.sv
module tlb_range_sel
    import tlb_flush_pkg::*;
#(
    parameter int CNT_W = 21
)(
    input  logic             cp0_usable,
    input  logic [2:0]       mmu_type,
    input  logic [1:0]       inv_mode,
    input  logic [CNT_W-1:0] index_val,
    input  logic [CNT_W-1:0] vtlb_size,
    input  logic [CNT_W-1:0] total_size,
    output action_t          action,
    output fault_t           fault,
    output logic [CNT_W-1:0] first,
    output logic [CNT_W-1:0] last,
    output logic [CNT_W-1:0] seek_off
);

    always_comb begin
        action   = ACT_FAULT;
        fault    = FLT_RESERVED;
        first    = '0;
        last     = '0;
        seek_off = '0;
        if (!cp0_usable) begin
            fault = FLT_COP_UNUSABLE;
        end else if (mmu_type == MMU_JOINT) begin
            action = ACT_WALK;
            fault  = FLT_NONE;
            last   = vtlb_size - CNT_W'(1);
        end else if (mmu_type == MMU_SPLIT && inv_mode == INV_HW_WALK) begin
            action = ACT_WALK;
            fault  = FLT_NONE;
            last   = total_size - CNT_W'(1);
        end else if (mmu_type == MMU_SPLIT && inv_mode == INV_SW_WALK) begin
            if (index_val < vtlb_size) begin
                action = ACT_WALK;
                fault  = FLT_NONE;
                last   = vtlb_size - CNT_W'(1);
            end else if (index_val >= total_size) begin
                fault = FLT_RANGE;
            end else begin
                action   = ACT_SEEK;
                fault    = FLT_NONE;
                first    = vtlb_size;
                seek_off = index_val - vtlb_size;
            end
        end
    end

endmodule

// File: rtl/tlb_walk_fsm.sv
module tlb_walk_fsm
    import tlb_flush_pkg::*;
#(
    parameter int CNT_W = 21
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  action_t          action,
    input  fault_t           fault,
    input  logic [CNT_W-1:0] first,
    input  logic [CNT_W-1:0] last,
    input  logic [CNT_W-1:0] seek_off,
    input  logic [CNT_W-1:0] way_count,
    output logic             busy,
    output logic             done,
    output logic             inv_we,
    output logic [CNT_W-1:0] inv_addr,
    output logic             exc_cpu_unusable,
    output logic             exc_reserved,
    output logic             err_index_range
);

    walk_state_t      state, state_nxt;
    logic [CNT_W-1:0] cur, stop, off;
    fault_t           flt;
    logic             set_found;

    assign set_found = (off < way_count);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start) state_nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (action)
                    ACT_WALK: state_nxt = ST_WALK;
                    ACT_SEEK: state_nxt = ST_SEEK;
                    default:  state_nxt = ST_FAULT;
                endcase
            end
            ST_SEEK:   if (set_found) state_nxt = ST_WALK;
            ST_WALK:   if (cur == stop) state_nxt = ST_DONE;
            ST_DONE:   state_nxt = ST_IDLE;
            ST_FAULT:  state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur  <= '0;
            stop <= '0;
            off  <= '0;
            flt  <= FLT_NONE;
        end else begin
            unique case (state)
                ST_DECODE: begin
                    cur  <= first;
                    stop <= last;
                    off  <= seek_off;
                    flt  <= fault;
                end
                ST_SEEK: begin
                    if (set_found) begin
                        stop <= cur + way_count - CNT_W'(1);
                    end else begin
                        off <= off - way_count;
                        cur <= cur + way_count;
                    end
                end
                ST_WALK: if (cur != stop) cur <= cur + CNT_W'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        busy             = (state != ST_IDLE);
        inv_we           = (state == ST_WALK);
        inv_addr         = cur;
        done             = (state == ST_DONE) || (state == ST_FAULT);
        exc_cpu_unusable = (state == ST_FAULT) && (flt == FLT_COP_UNUSABLE);
        exc_reserved     = (state == ST_FAULT) && (flt == FLT_RESERVED);
        err_index_range  = (state == ST_FAULT) && (flt == FLT_RANGE);
    end

endmodule

// File: rtl/tlb_flush_walker.sv
module tlb_flush_walker
    import tlb_flush_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int VEXT_W = 4,
    parameter int MEXT_W = 3,
    parameter int WAYS_W = 4,
    parameter int SETS_W = 4,
    localparam int VSZ_W = VEXT_W + BASE_W + 1,
    localparam int FSZ_W = WAYS_W + 1 + (1 << SETS_W) - 1,
    localparam int TOT_W = ((VSZ_W > FSZ_W) ? VSZ_W : FSZ_W) + 1,
    localparam int CNT_W = (TOT_W > IDX_W) ? TOT_W : IDX_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cp0_usable,
    input  logic [2:0]        mmu_type,
    input  logic [1:0]        inv_mode,
    input  logic [IDX_W-1:0]  index_val,
    input  logic              rev6_mode,
    input  logic [1:0]        ext_def,
    input  logic [VEXT_W-1:0] vtlb_ext,
    input  logic [MEXT_W-1:0] mmu_ext,
    input  logic [BASE_W-1:0] base_size,
    input  logic [WAYS_W-1:0] ftlb_ways,
    input  logic [SETS_W-1:0] ftlb_sets,
    output logic              busy,
    output logic              done,
    output logic              inv_we,
    output logic [CNT_W-1:0]  inv_addr,
    output logic              exc_cpu_unusable,
    output logic              exc_reserved,
    output logic              err_index_range
);

    logic              accept;
    logic              q_cp0;
    logic [2:0]        q_type;
    logic [1:0]        q_mode;
    logic [CNT_W-1:0]  q_index;
    logic              q_rev6;
    logic [1:0]        q_extdef;
    logic [VEXT_W-1:0] q_vext;
    logic [MEXT_W-1:0] q_mext;
    logic [BASE_W-1:0] q_base;
    logic [WAYS_W-1:0] q_ways;
    logic [SETS_W-1:0] q_sets;

    logic [CNT_W-1:0]  vtlb_size, total_size, way_count;
    logic [CNT_W-1:0]  first, last, seek_off;
    action_t           action;
    fault_t            fault;

    assign accept = cmd_valid && !busy;

    // Command fields are held for the whole walk so later input changes are ignored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cp0    <= 1'b0;
            q_type   <= '0;
            q_mode   <= '0;
            q_index  <= '0;
            q_rev6   <= 1'b0;
            q_extdef <= '0;
            q_vext   <= '0;
            q_mext   <= '0;
            q_base   <= '0;
            q_ways   <= '0;
            q_sets   <= '0;
        end else if (accept) begin
            q_cp0    <= cp0_usable;
            q_type   <= mmu_type;
            q_mode   <= inv_mode;
            q_index  <= CNT_W'(index_val);
            q_rev6   <= rev6_mode;
            q_extdef <= ext_def;
            q_vext   <= vtlb_ext;
            q_mext   <= mmu_ext;
            q_base   <= base_size;
            q_ways   <= ftlb_ways;
            q_sets   <= ftlb_sets;
        end
    end

    tlb_size_calc #(
        .VEXT_W (VEXT_W),
        .MEXT_W (MEXT_W),
        .WAYS_W (WAYS_W),
        .SETS_W (SETS_W),
        .CNT_W  (CNT_W)
    ) size_i (
        .rev6_mode  (q_rev6),
        .ext_def    (q_extdef),
        .vtlb_ext   (q_vext),
        .mmu_ext    (q_mext),
        .base_size  (q_base),
        .ftlb_ways  (q_ways),
        .ftlb_sets  (q_sets),
        .mmu_type   (q_type),
        .vtlb_size  (vtlb_size),
        .total_size (total_size),
        .way_count  (way_count)
    );

    tlb_range_sel #(
        .CNT_W (CNT_W)
    ) range_i (
        .cp0_usable (q_cp0),
        .mmu_type   (q_type),
        .inv_mode   (q_mode),
        .index_val  (q_index),
        .vtlb_size  (vtlb_size),
        .total_size (total_size),
        .action     (action),
        .fault      (fault),
        .first      (first),
        .last       (last),
        .seek_off   (seek_off)
    );

    tlb_walk_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .start            (accept),
        .action           (action),
        .fault            (fault),
        .first            (first),
        .last             (last),
        .seek_off         (seek_off),
        .way_count        (way_count),
        .busy             (busy),
        .done             (done),
        .inv_we           (inv_we),
        .inv_addr         (inv_addr),
        .exc_cpu_unusable (exc_cpu_unusable),
        .exc_reserved     (exc_reserved),
        .err_index_range  (err_index_range)
    );

endmodule

// File: rtl/tlb_flush_walker_chk.sv
module tlb_flush_walker_chk #(
    parameter int CNT_W = 21
)(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             busy,
    input logic             done,
    input logic             inv_we,
    input logic [CNT_W-1:0] inv_addr,
    input logic             exc_cpu_unusable,
    input logic             exc_reserved,
    input logic             err_index_range
);

    logic any_exc;
    assign any_exc = exc_cpu_unusable || exc_reserved || err_index_range;

    // R1
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R9
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_we |-> busy);

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_we && $past(inv_we)) |-> (inv_addr == $past(inv_addr) + CNT_W'(1)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !any_exc) |-> $past(inv_we));

    // R12
    cpu_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_cpu_unusable |-> !$past(inv_we));

    // R13
    exc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_cpu_unusable, exc_reserved, err_index_range}));

    // R13
    exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_exc |-> done);

endmodule

bind tlb_flush_walker tlb_flush_walker_chk #(.CNT_W(CNT_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_valid        (cmd_valid),
    .busy             (busy),
    .done             (done),
    .inv_we           (inv_we),
    .inv_addr         (inv_addr),
    .exc_cpu_unusable (exc_cpu_unusable),
    .exc_reserved     (exc_reserved),
    .err_index_range  (err_index_range)
);

// File: tb/tlb_flush_walker_tb_top.sv
`timescale 1ns/1ps
module tlb_flush_walker_tb_top;

    localparam int IDX_W  = 16;
    localparam int VEXT_W = 4;
    localparam int MEXT_W = 3;
    localparam int WAYS_W = 4;
    localparam int SETS_W = 4;
    localparam int VSZ_W  = VEXT_W + 6 + 1;
    localparam int FSZ_W  = WAYS_W + 1 + (1 << SETS_W) - 1;
    localparam int TOT_W  = ((VSZ_W > FSZ_W) ? VSZ_W : FSZ_W) + 1;
    localparam int CNT_W  = (TOT_W > IDX_W) ? TOT_W : IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic              cp0_usable = 1'b1;
    logic [2:0]        mmu_type = '0;
    logic [1:0]        inv_mode = '0;
    logic [IDX_W-1:0]  index_val = '0;
    logic              rev6_mode = 1'b0;
    logic [1:0]        ext_def = '0;
    logic [VEXT_W-1:0] vtlb_ext = '0;
    logic [MEXT_W-1:0] mmu_ext = '0;
    logic [5:0]        base_size = '0;
    logic [WAYS_W-1:0] ftlb_ways = '0;
    logic [SETS_W-1:0] ftlb_sets = '0;
    logic              busy, done, inv_we;
    logic [CNT_W-1:0]  inv_addr;
    logic              exc_cpu_unusable, exc_reserved, err_index_range;

    tlb_flush_walker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cp0_usable(cp0_usable),
        .mmu_type(mmu_type), .inv_mode(inv_mode), .index_val(index_val),
        .rev6_mode(rev6_mode), .ext_def(ext_def), .vtlb_ext(vtlb_ext), .mmu_ext(mmu_ext),
        .base_size(base_size), .ftlb_ways(ftlb_ways), .ftlb_sets(ftlb_sets),
        .busy(busy), .done(done), .inv_we(inv_we), .inv_addr(inv_addr),
        .exc_cpu_unusable(exc_cpu_unusable), .exc_reserved(exc_reserved),
        .err_index_range(err_index_range)
    );

    int    vectors = 0;
    int    misses = 0;
    bit    finished = 0;
    bit    monitoring = 0;
    bit    prev_we = 0;
    string cur_req = "R1";
    longint unsigned exp_addr[$];
    logic [2:0]      exp_out[$];   // {cpu_unusable, reserved, index_range}

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard as writes and completions appear.
    always @(negedge clk) begin
        if (monitoring) begin
            if (inv_we) begin
                if (exp_addr.size() == 0) begin
                    check(0, cur_req, "R9 unexpected write", longint'(inv_addr), -1);
                end else begin
                    longint unsigned e;
                    e = exp_addr.pop_front();
                    check(inv_addr == CNT_W'(e), cur_req, "write address", longint'(inv_addr), longint'(e));
                end
            end
            if (done) begin
                logic [2:0] o;
                o = {exc_cpu_unusable, exc_reserved, err_index_range};
                if (exp_out.size() == 0) begin
                    check(0, cur_req, "R1 unexpected done", longint'(o), -1);
                end else begin
                    logic [2:0] eo;
                    eo = exp_out.pop_front();
                    check(o == eo, cur_req, "exception flags", longint'(o), longint'(eo));
                end
                check(exp_addr.size() == 0, cur_req, "writes missing at done",
                      longint'(exp_addr.size()), 0);
                if (o == 3'b000)
                    check(prev_we, "R10", "write in cycle before done", longint'(prev_we), 1);
            end
            prev_we = inv_we;
        end
    end

    // Driver: computes the expected outcome from the requirements and issues one command.
    task automatic send(input string req, input bit cp0, input int ty, input int md,
                        input int idx, input bit r6, input int def, input int vext,
                        input int mext, input int base, input int ways, input int sets,
                        input bit poke);
        int ext, vs, fs, w, tot, lo, hi, s;
        logic [2:0] out;
        bit walk;
        w = ways + 2;
        if (r6 || def == 3) ext = vext;
        else if (def == 1) ext = mext;
        else ext = 0;
        vs = 1 + ((ext << 6) | base);
        fs = (ty == 4) ? (w << sets) : 0;
        tot = vs + fs;
        walk = 0; out = 3'b000; lo = 0; hi = 0;
        if (!cp0) out = 3'b100;
        else if (ty == 1) begin walk = 1; hi = vs - 1; end
        else if (ty == 4 && md == 3) begin walk = 1; hi = tot - 1; end
        else if (ty == 4 && md == 2) begin
            if (idx < vs) begin walk = 1; hi = vs - 1; end
            else if (idx >= tot) out = 3'b001;
            else begin
                s = (idx - vs) / w;
                walk = 1; lo = vs + s * w; hi = lo + w - 1;
            end
        end else out = 3'b010;
        if (walk) for (int a = lo; a <= hi; a++) exp_addr.push_back(longint'(a));
        exp_out.push_back(out);

        @(negedge clk);
        cur_req    = req;
        cp0_usable = cp0;
        mmu_type   = 3'(ty);
        inv_mode   = 2'(md);
        index_val  = IDX_W'(idx);
        rev6_mode  = r6;
        ext_def    = 2'(def);
        vtlb_ext   = VEXT_W'(vext);
        mmu_ext    = MEXT_W'(mext);
        base_size  = 6'(base);
        ftlb_ways  = WAYS_W'(ways);
        ftlb_sets  = SETS_W'(sets);
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy == 1'b1, "R1", "busy after accept", longint'(busy), 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            cp0_usable = 1'b0;
            mmu_type   = 3'd2;
            cmd_valid  = 1'b1;
            @(negedge clk);
            cmd_valid  = 1'b0;
        end
        do @(negedge clk); while (!done);
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy clear after done", longint'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && inv_we == 0, "R1", "reset outputs idle",
              longint'({busy, done, inv_we}), 0);
        check({exc_cpu_unusable, exc_reserved, err_index_range} == 3'b000, "R13",
              "reset flags clear", longint'({exc_cpu_unusable, exc_reserved, err_index_range}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        monitoring = 1;

        // joint array: Index and fixed-page fields ignored
        send("R2", 1, 1, 0, 100, 0, 0, 0, 0, 5, 3, 2, 0);
        // hardware walk: V=4, F=2*4=8 -> entries 0..11
        send("R3", 1, 4, 3, 999, 0, 0, 0, 0, 3, 0, 2, 0);
        // R8: ways field 1 -> 3 ways, sets field 1 -> F=6, V=1
        send("R8", 1, 4, 3, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        send("R9", 1, 4, 3, 7, 0, 0, 0, 0, 1, 1, 0, 0);
        // software walk, V=4, W=2, 4 sets, total 12
        send("R4", 1, 4, 2, 2, 0, 0, 0, 0, 3, 0, 2, 0);
        send("R4", 1, 4, 2, 3, 0, 0, 0, 0, 3, 0, 2, 0);
        send("R5", 1, 4, 2, 4, 0, 0, 0, 0, 3, 0, 2, 0);
        send("R5", 1, 4, 2, 7, 0, 0, 0, 0, 3, 0, 2, 0);
        send("R5", 1, 4, 2, 11, 0, 0, 0, 0, 3, 0, 2, 0);
        send("R5", 1, 4, 2, 13, 0, 0, 0, 0, 2, 1, 2, 0);
        send("R6", 1, 4, 2, 12, 0, 0, 0, 0, 3, 0, 2, 0);
        send("R6", 1, 4, 2, 60000, 0, 0, 0, 0, 3, 0, 2, 0);
        // size extension selection
        send("R7", 1, 1, 0, 0, 1, 0, 1, 0, 2, 0, 0, 0);
        send("R7", 1, 1, 0, 0, 0, 1, 0, 1, 2, 0, 0, 0);
        send("R7", 1, 1, 0, 0, 0, 0, 1, 1, 2, 0, 0, 0);
        send("R7", 1, 1, 0, 0, 0, 3, 1, 0, 2, 0, 0, 0);
        // reserved cases
        send("R11", 1, 2, 2, 0, 0, 0, 0, 0, 3, 0, 0, 0);
        send("R11", 1, 3, 3, 0, 0, 0, 0, 0, 3, 0, 0, 0);
        send("R11", 1, 0, 3, 0, 0, 0, 0, 0, 3, 0, 0, 0);
        send("R11", 1, 4, 1, 0, 0, 0, 0, 0, 3, 0, 0, 0);
        // coprocessor disabled takes priority
        send("R12", 0, 1, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0);
        send("R12", 0, 2, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0);
        send("R13", 0, 4, 2, 60000, 0, 0, 0, 0, 3, 0, 2, 0);
        // command during a long walk is ignored
        send("R1", 1, 1, 0, 0, 0, 0, 0, 0, 30, 0, 0, 1);
        send("R10", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        repeat (3) @(negedge clk);
        check(exp_out.size() == 0, "R1", "all completions seen", longint'(exp_out.size()), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            misses++;
            $display("FAIL R1 watchdog expired: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule